// File: doc/BRIEF.md
# Offload Result Channel Protocol Monitor

This block is a synthesizable watcher that sits on the link between a processor core and an attached coprocessor. It observes two streams: the commit stream, on which the core tells the coprocessor whether each offloaded instruction may retire or must be discarded, and the result stream, a valid/ready handshake on which the coprocessor returns write-back information. The block drives neither side. It only reports protocol breaches.

A bitmap with one entry per possible instruction id records which ids are currently cleared to commit. A result is flagged as premature when it opens for an id that is not cleared. While a result transfer waits for ready, the block holds a copy of its fields and compares it with the live values. It also checks the pairing rule of the two-bit write enable, the strict increment of commit ids, and that valid is not dropped early. Each kind of breach has its own sticky flag. The id of the first offending transfer is latched so that a debug environment can locate it.

Top module: `xres_monitor`

## Requirements
- R1: After reset, and for two clock cycles after the reset input is released (the internal synchronizer delay), all error flags and `first_err_valid` are 0.
- R2: Bit 0 of `err_flags` sets when a result transfer opens (`result_valid` = 1 with no transfer pending) for an id that has no outstanding non-kill commit. A commit with `commit_kill` = 1 grants nothing. A non-kill commit for the same id in the same cycle counts as granted.
- R3: A completed result handshake (`result_valid` and `result_ready` both 1) consumes the grant of its id. A second result for that id without a new commit sets bit 0.
- R4: Bit 1 sets when, during a pending transfer, `result_id`, `result_we` or `result_rd` differs from its value at the transfer's opening cycle. A change in `result_data` sets bit 1 only when the held write enable is nonzero.
- R5: Bit 4 sets when `result_valid` falls to 0 while a transfer is pending, that is, after a cycle with valid = 1 and ready = 0.
- R6: With a two-bit write enable (register write width 64, XLEN 32), bit 2 sets when `result_valid` = 1 and `result_we` = 2'b10. The values 2'b00, 2'b01 and 2'b11 are legal.
- R7: Bit 3 sets when a commit id is not the previous commit id plus one, modulo 2^ID_WIDTH. The first commit after reset may carry any id, and wrapping from the largest id to 0 is legal.
- R8: Error flags are sticky. Once set, they are cleared only by reset.
- R9: `first_err_id` latches the id of the first violation and `first_err_valid` rises with it. For a result violation the id is that of the transfer (the held id if the transfer is pending). For a commit-order violation it is the commit id. A result violation wins when both occur in the same cycle. Later violations do not change it.
- R10: Flags and the first-error record update on the clock edge that samples the offending inputs, and they are not visible before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| commit_valid | input | 1 | Commit handshake strobe |
| commit_id | input | ID_WIDTH | Id of the committed instruction |
| commit_kill | input | 1 | 1 = discard the instruction, 0 = allowed to commit |
| result_valid | input | 1 | Result offered by the coprocessor |
| result_ready | input | 1 | Result taken by the core |
| result_id | input | ID_WIDTH | Id of the result |
| result_we | input | WE_W | Register write enables (2 bits when the write width is 64 and XLEN is 32, otherwise 1) |
| result_rd | input | 5 | Destination register |
| result_data | input | RFW_WIDTH | Write-back data |
| err_flags | output | 5 | Sticky flags: bit0 premature, bit1 unstable, bit2 enable order, bit3 commit order, bit4 dropped valid |
| first_err_valid | output | 1 | A first error has been recorded |
| first_err_id | output | ID_WIDTH | Id of the first violation |

## Verification
Every flag and the first-error record is due exactly one clock after the cycle that holds the offending inputs, because each passes through a single register stage. The bench changes inputs on the falling edge and reads outputs on the next falling edge. For R10 it also reads just after driving, before the rising edge, and expects no flag yet. Random legal traffic with random wait states and changing don't-care data must leave every flag clear. Random write-enable codes are compared against a bench function that decides legality.

// File: rtl/xres_pkg.sv
package xres_pkg;
  localparam int unsigned ERR_N        = 5;
  localparam int unsigned ERR_EARLY    = 0;
  localparam int unsigned ERR_UNSTABLE = 1;
  localparam int unsigned ERR_WE_ORDER = 2;
  localparam int unsigned ERR_CMT_SEQ  = 3;
  localparam int unsigned ERR_DROPPED  = 4;
  localparam int unsigned RD_W         = 5;

  function automatic int unsigned we_width(input int unsigned rfw, input int unsigned xlen);
    return (rfw == 64 && xlen == 32) ? 2 : 1;
  endfunction
endpackage

// File: rtl/xres_commit_track.sv
module xres_commit_track #(
  parameter int unsigned ID_WIDTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                commit_valid,
  input  logic [ID_WIDTH-1:0] commit_id,
  input  logic                commit_kill,
  input  logic                res_fire,
  input  logic [ID_WIDTH-1:0] res_id,
  output logic                granted,
  output logic                seq_err
);
  localparam int unsigned  N_IDS  = 1 << ID_WIDTH;
  localparam logic [ID_WIDTH-1:0] ID_ONE = ID_WIDTH'(1);

  logic [N_IDS-1:0]    grant_q, grant_d;
  logic [ID_WIDTH-1:0] last_q;
  logic                seen_q;
  logic                cmt_ok;

  assign cmt_ok  = commit_valid & ~commit_kill;
  assign granted = grant_q[res_id] | (cmt_ok & (commit_id == res_id));
  assign seq_err = commit_valid & seen_q & (commit_id != (last_q + ID_ONE));

  always_comb begin
    grant_d = grant_q;
    for (int i = 0; i < int'(N_IDS); i++) begin
      if (commit_valid && (commit_id == ID_WIDTH'(i)))
        grant_d[i] = ~commit_kill;
      if (res_fire && (res_id == ID_WIDTH'(i)))
        grant_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      last_q  <= '0;
      seen_q  <= 1'b0;
    end else begin
      grant_q <= grant_d;
      if (commit_valid) begin
        last_q <= commit_id;
        seen_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/xres_result_watch.sv
module xres_result_watch #(
  parameter int unsigned ID_WIDTH = 4,
  parameter int unsigned WE_W     = 2,
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned RD_W     = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                result_valid,
  input  logic                result_ready,
  input  logic [ID_WIDTH-1:0] result_id,
  input  logic [WE_W-1:0]     result_we,
  input  logic [RD_W-1:0]     result_rd,
  input  logic [DATA_W-1:0]   result_data,
  output logic                opening,
  output logic                unstable_err,
  output logic                drop_err,
  output logic                we_err,
  output logic [ID_WIDTH-1:0] err_id
);
  logic                pend_q, pend_d;
  logic                cap_en;
  logic [ID_WIDTH-1:0] h_id_q;
  logic [WE_W-1:0]     h_we_q;
  logic [RD_W-1:0]     h_rd_q;
  logic [DATA_W-1:0]   h_data_q;
  logic                data_moved;

  assign opening    = result_valid & ~pend_q;
  assign cap_en     = opening;
  assign pend_d     = result_valid & ~result_ready;
  assign data_moved = (h_we_q != '0) && (h_data_q != result_data);
  assign unstable_err = pend_q & result_valid &
                        ((h_id_q != result_id) || (h_we_q != result_we) ||
                         (h_rd_q != result_rd) || data_moved);
  assign drop_err = pend_q & ~result_valid;
  assign err_id   = pend_q ? h_id_q : result_id;

  generate
    if (WE_W == 2) begin : g_pair
      assign we_err = result_valid & result_we[1] & ~result_we[0];
    end else begin : g_single
      assign we_err = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      h_id_q   <= '0;
      h_we_q   <= '0;
      h_rd_q   <= '0;
      h_data_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (cap_en) begin
        h_id_q   <= result_id;
        h_we_q   <= result_we;
        h_rd_q   <= result_rd;
        h_data_q <= result_data;
      end
    end
  end
endmodule

// File: rtl/xres_err_log.sv
module xres_err_log #(
  parameter int unsigned ID_WIDTH = 4,
  parameter int unsigned ERR_N    = 5,
  parameter int unsigned CMT_BIT  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ERR_N-1:0]    err_pulse,
  input  logic [ID_WIDTH-1:0] res_id,
  input  logic [ID_WIDTH-1:0] cmt_id,
  output logic [ERR_N-1:0]    err_flags,
  output logic                first_valid,
  output logic [ID_WIDTH-1:0] first_id
);
  logic [ERR_N-1:0]    flags_d;
  logic                first_en;
  logic                res_hit;
  logic [ID_WIDTH-1:0] id_pick;
  logic [ERR_N-1:0]    res_mask;

  always_comb begin
    res_mask          = '1;
    res_mask[CMT_BIT] = 1'b0;
  end

  assign flags_d  = err_flags | err_pulse;
  assign res_hit  = |(err_pulse & res_mask);
  assign id_pick  = res_hit ? res_id : cmt_id;
  assign first_en = ~first_valid & (|err_pulse);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flags   <= '0;
      first_valid <= 1'b0;
      first_id    <= '0;
    end else begin
      err_flags <= flags_d;
      if (first_en) begin
        first_valid <= 1'b1;
        first_id    <= id_pick;
      end
    end
  end
endmodule

// File: rtl/xres_monitor.sv
module xres_monitor
  import xres_pkg::*;
#(
  parameter int unsigned ID_WIDTH  = 4,
  parameter int unsigned XLEN      = 32,
  parameter int unsigned RFW_WIDTH = 64,
  localparam int unsigned WE_W     = we_width(RFW_WIDTH, XLEN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 commit_valid,
  input  logic [ID_WIDTH-1:0]  commit_id,
  input  logic                 commit_kill,
  input  logic                 result_valid,
  input  logic                 result_ready,
  input  logic [ID_WIDTH-1:0]  result_id,
  input  logic [WE_W-1:0]      result_we,
  input  logic [RD_W-1:0]      result_rd,
  input  logic [RFW_WIDTH-1:0] result_data,
  output logic [ERR_N-1:0]     err_flags,
  output logic                 first_err_valid,
  output logic [ID_WIDTH-1:0]  first_err_id
);
  logic [1:0]          rst_sync_q;
  logic                rst_i;
  logic                granted, seq_err, opening;
  logic                unstable_err, drop_err, we_err;
  logic [ID_WIDTH-1:0] res_err_id;
  logic [ERR_N-1:0]    pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  xres_commit_track #(.ID_WIDTH(ID_WIDTH)) u_track (
    .clk(clk), .rst_n(rst_i),
    .commit_valid(commit_valid), .commit_id(commit_id), .commit_kill(commit_kill),
    .res_fire(result_valid & result_ready), .res_id(result_id),
    .granted(granted), .seq_err(seq_err)
  );

  xres_result_watch #(.ID_WIDTH(ID_WIDTH), .WE_W(WE_W), .DATA_W(RFW_WIDTH), .RD_W(RD_W)) u_watch (
    .clk(clk), .rst_n(rst_i),
    .result_valid(result_valid), .result_ready(result_ready),
    .result_id(result_id), .result_we(result_we), .result_rd(result_rd),
    .result_data(result_data),
    .opening(opening), .unstable_err(unstable_err), .drop_err(drop_err),
    .we_err(we_err), .err_id(res_err_id)
  );

  always_comb begin
    pulse               = '0;
    pulse[ERR_EARLY]    = opening & ~granted;
    pulse[ERR_UNSTABLE] = unstable_err;
    pulse[ERR_WE_ORDER] = we_err;
    pulse[ERR_CMT_SEQ]  = seq_err;
    pulse[ERR_DROPPED]  = drop_err;
  end

  xres_err_log #(.ID_WIDTH(ID_WIDTH), .ERR_N(ERR_N), .CMT_BIT(ERR_CMT_SEQ)) u_log (
    .clk(clk), .rst_n(rst_i),
    .err_pulse(pulse), .res_id(res_err_id), .cmt_id(commit_id),
    .err_flags(err_flags), .first_valid(first_err_valid), .first_id(first_err_id)
  );
endmodule

// File: rtl/xres_monitor_chk.sv
module xres_monitor_chk
  import xres_pkg::*;
#(
  parameter int unsigned ID_WIDTH = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                commit_valid,
  input logic                result_valid,
  input logic [ERR_N-1:0]    err_flags,
  input logic                first_err_valid,
  input logic [ID_WIDTH-1:0] first_err_id
);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags != '0) |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  assert_first_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    first_err_valid |=> (first_err_valid && $stable(first_err_id)));

  assert_first_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(first_err_valid) |-> (err_flags != '0));

  assert_early_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[ERR_EARLY]) |-> $past(result_valid));

  assert_we_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[ERR_WE_ORDER]) |-> $past(result_valid));

  assert_seq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[ERR_CMT_SEQ]) |-> $past(commit_valid));

  assert_drop_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[ERR_DROPPED]) |-> !$past(result_valid));
endmodule

bind xres_monitor xres_monitor_chk #(.ID_WIDTH(ID_WIDTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .commit_valid(commit_valid),
  .result_valid(result_valid), .err_flags(err_flags),
  .first_err_valid(first_err_valid), .first_err_id(first_err_id)
);

// File: tb/test_xres_monitor.sv
`timescale 1ns/1ps
module test_xres_monitor;
  localparam int IDW = 4;
  localparam int WEW = 2;
  localparam int DW  = 64;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           commit_valid, commit_kill;
  logic [IDW-1:0] commit_id;
  logic           result_valid, result_ready;
  logic [IDW-1:0] result_id;
  logic [WEW-1:0] result_we;
  logic [4:0]     result_rd;
  logic [DW-1:0]  result_data;
  logic [4:0]     err_flags;
  logic           first_err_valid;
  logic [IDW-1:0] first_err_id;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  xres_monitor i_xres_monitor (
    .clk(clk), .rst_n(rst_n),
    .commit_valid(commit_valid), .commit_id(commit_id), .commit_kill(commit_kill),
    .result_valid(result_valid), .result_ready(result_ready),
    .result_id(result_id), .result_we(result_we), .result_rd(result_rd),
    .result_data(result_data),
    .err_flags(err_flags), .first_err_valid(first_err_valid), .first_err_id(first_err_id)
  );

  function automatic bit we_bad(input logic [1:0] we);
    return we == 2'b10;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    commit_valid = 0; commit_kill = 0; commit_id = '0;
    result_valid = 0; result_ready = 0; result_id = '0;
    result_we = '0; result_rd = '0; result_data = '0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic commit(input logic [IDW-1:0] id, input logic kill);
    commit_valid = 1; commit_id = id; commit_kill = kill;
    @(negedge clk);
    commit_valid = 0; commit_kill = 0;
  endtask

  task automatic result(input logic [IDW-1:0] id, input logic [1:0] we);
    result_valid = 1; result_ready = 1; result_id = id; result_we = we;
    result_rd = 5'd7; result_data = 64'hA5;
    @(negedge clk);
    result_valid = 0; result_ready = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    idle_inputs();
    rst_n = 0;
    #1;
    // R1: reset state, including the synchronizer window
    rst_n = 0; repeat (3) @(negedge clk);
    chk("R1 flags in reset", 32'(err_flags), 0);
    rst_n = 1; @(negedge clk);
    result_valid = 1; result_id = 4'd2; // violation during sync window is ignored
    @(negedge clk); result_valid = 0;
    repeat (3) @(negedge clk);
    chk("R1 flags after reset", 32'(err_flags), 0);
    chk("R1 first valid", 32'(first_err_valid), 0);

    // R2 + R10: premature result, flag only after the edge
    do_reset();
    result_valid = 1; result_ready = 1; result_id = 4'd3; result_we = 2'b01;
    #1;
    chk("R10 not before edge", 32'(err_flags), 0);
    @(negedge clk); result_valid = 0; result_ready = 0;
    chk("R2 premature", 32'(err_flags), 32'h01);
    chk("R9 first id premature", 32'(first_err_id), 3);
    chk("R9 first valid", 32'(first_err_valid), 1);

    // R2: killed commit grants nothing
    do_reset();
    commit(4'd0, 1'b1);
    result(4'd0, 2'b01);
    chk("R2 killed commit", 32'(err_flags), 32'h01);

    // R2: same-cycle commit and result are legal
    do_reset();
    commit_valid = 1; commit_id = 4'd5;
    result_valid = 1; result_ready = 1; result_id = 4'd5; result_we = 2'b01;
    @(negedge clk); idle_inputs();
    @(negedge clk);
    chk("R2 same cycle", 32'(err_flags), 0);

    // R3: grant consumed by handshake
    do_reset();
    commit(4'd2, 1'b0);
    result(4'd2, 2'b11);
    chk("R3 first result ok", 32'(err_flags), 0);
    result(4'd2, 2'b11);
    chk("R3 reuse without commit", 32'(err_flags), 32'h01);

    // R4: rd change while pending
    do_reset();
    commit(4'd1, 1'b0);
    result_valid = 1; result_id = 4'd1; result_we = 2'b01; result_rd = 5'd4; result_data = 64'h11;
    @(negedge clk); result_rd = 5'd9;
    @(negedge clk); result_ready = 1;
    @(negedge clk); idle_inputs();
    chk("R4 rd change", 32'(err_flags), 32'h02);
    chk("R9 held id", 32'(first_err_id), 1);

    // R4: data change allowed when no enable
    do_reset();
    commit(4'd1, 1'b0);
    result_valid = 1; result_id = 4'd1; result_we = 2'b00; result_data = 64'h11;
    @(negedge clk); result_data = 64'h22;
    @(negedge clk); result_data = 64'h33; result_ready = 1;
    @(negedge clk); idle_inputs();
    chk("R4 data free when we=0", 32'(err_flags), 0);

    // R4: data change flagged when enabled
    do_reset();
    commit(4'd1, 1'b0);
    result_valid = 1; result_id = 4'd1; result_we = 2'b11; result_data = 64'h11;
    @(negedge clk); result_data = 64'h22; result_ready = 1;
    @(negedge clk); idle_inputs();
    chk("R4 data change with we", 32'(err_flags), 32'h02);

    // R5: dropped valid
    do_reset();
    commit(4'd1, 1'b0);
    result_valid = 1; result_id = 4'd1; result_we = 2'b01;
    @(negedge clk); result_valid = 0; result_id = 4'd8;
    @(negedge clk);
    chk("R5 dropped valid", 32'(err_flags), 32'h10);
    chk("R9 dropped id", 32'(first_err_id), 1);

    // R6: enable ordering
    do_reset();
    commit(4'd4, 1'b0);
    result(4'd4, 2'b10);
    chk("R6 bad enable", 32'(err_flags), 32'h04);
    do_reset();
    commit(4'd4, 1'b0);
    result(4'd4, 2'b11);
    chk("R6 dual ok", 32'(err_flags), 0);

    // R7: wrap legal, skip flagged
    do_reset();
    commit(4'd15, 1'b0);
    commit(4'd0, 1'b0);
    commit(4'd1, 1'b1);
    chk("R7 wrap ok", 32'(err_flags), 0);
    commit(4'd3, 1'b0);
    chk("R7 skip", 32'(err_flags), 32'h08);
    chk("R9 commit id", 32'(first_err_id), 3);

    // R8 + R9: sticky and first id kept
    do_reset();
    result(4'd6, 2'b01);
    commit(4'd8, 1'b0);
    commit(4'd9, 1'b0);
    commit(4'd2, 1'b0);
    result(4'd2, 2'b01);
    repeat (3) @(negedge clk);
    chk("R8 sticky", 32'(err_flags), 32'h09);
    chk("R9 first kept", 32'(first_err_id), 6);
    do_reset();
    chk("R8 reset clears", 32'(err_flags), 0);

    // R9: result wins over commit in same cycle
    do_reset();
    commit(4'd1, 1'b0);
    commit_valid = 1; commit_id = 4'd7;
    result_valid = 1; result_ready = 1; result_id = 4'd12; result_we = 2'b01;
    @(negedge clk); idle_inputs();
    chk("R9 priority flags", 32'(err_flags), 32'h09);
    chk("R9 priority id", 32'(first_err_id), 12);

    // Random legal traffic: R2 R3 R4 R7 stay clean
    do_reset();
    begin
      logic [IDW-1:0] nid;
      nid = 4'd0;
      for (int it = 0; it < 60; it++) begin
        logic [1:0] we;
        int wait_n;
        commit(nid, 1'b0);
        repeat ($urandom_range(0, 2)) @(negedge clk);
        case ($urandom_range(0, 2))
          0: we = 2'b00;
          1: we = 2'b01;
          default: we = 2'b11;
        endcase
        wait_n = $urandom_range(0, 3);
        result_valid = 1; result_id = nid; result_we = we;
        result_rd = 5'($urandom); result_data = {$urandom, $urandom};
        for (int w = 0; w < wait_n; w++) begin
          @(negedge clk);
          if (we == 2'b00) result_data = {$urandom, $urandom};
        end
        result_ready = 1;
        @(negedge clk);
        result_valid = 0; result_ready = 0;
        nid = nid + 4'd1;
      end
      @(negedge clk);
      chk("R4 random legal traffic", 32'(err_flags), 0);
    end

    // Random enable codes: R6
    for (int it = 0; it < 16; it++) begin
      logic [1:0] we;
      we = 2'($urandom);
      do_reset();
      commit(4'd5, 1'b0);
      result(4'd5, we);
      chk("R6 random enable", 32'(err_flags[2]), 32'(we_bad(we)));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule